// File: doc/BRIEF.md
# Dual-View Peripheral Protection Configurator

This block holds the per-port security settings for ten peripheral protection controllers. Two of them guard internal APB peripherals, four guard expansion APB peripherals and four guard expansion AHB peripherals. Each controller stores three port masks. The non-secure mask marks which ports belong to the non-secure world. The secure-privilege mask gives the access permission for ports that stay secure. The non-secure-privilege mask gives the access permission for ports handed to the non-secure world. From these masks the block drives two registered flags per port: a non-secure flag and an access-permission flag.

Software reaches the masks through two 4 KB register windows, each with its own APB-style port. The secure window owns the non-secure masks and the secure-privilege masks. The non-secure window sees only the non-secure-privilege masks. Read data is registered in the setup phase and is valid in the access phase. Unmapped offsets read as zero and never signal an error.

Top module: `prot_cfg_top`

## Requirements
- R1: While rst_ni is low, and right after it is released, every mask is zero. So `nonsec_o`, `ap_o` and every mask readback are zero.
- R2: A word write in the secure window to a non-secure-mask offset stores the value. The matching 32-bit slot of `nonsec_o` shows it after that access edge. Slots are numbered as follows: 0–1 are the internal APB controllers, 2–5 the expansion APB controllers and 6–9 the expansion AHB controllers. Slot k is `nonsec_o[32k+31:32k]`.
- R3: For every port, the `ap_o` bit equals the non-secure-privilege bit when that port's non-secure bit is 1. Otherwise it equals the secure-privilege bit.
- R4: In the secure window the non-secure masks sit at 0x60 + 4i for expansion AHB, 0x70/0x74 for internal APB and 0x80 + 4i for expansion APB. The secure-privilege masks sit at 0xA0 + 4i, 0xB0/0xB4 and 0xC0 + 4i in the same group order. Address bits [3:2] give i. 0x78 and 0x7C (and 0xB8/0xBC) are unmapped.
- R5: The non-secure window maps only the non-secure-privilege masks, at 0xA0–0xAC, 0xB0/0xB4 and 0xC0–0xCC. These are separate storage from the secure-privilege masks at the same secure-window offsets. The non-secure window cannot reach any other mask.
- R6: Offsets 0x50 and 0x90, and every other unmapped offset in either window, read zero, and writes to them change nothing.
- R7: A write takes effect only when its size code is 2 (word) and address bits [1:0] are 0. Size code 0 (byte), code 1 (halfword), code 3 and misaligned word writes are ignored.
- R8: For a read with size code 0, the data is the register byte at bit 8·a, where a is address bits [1:0]. For size code 1 it is the 16 bits from bit 8·a, zero-filled above bit 31. Any other size code returns the whole register. Upper result bits are zero.
- R9: Each controller keeps only its low N mask bits, where N is its port count (APB0_PORTS, APB1_PORTS, EXP_PORTS, at most 32). Higher bits read zero and never appear on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_psel_i | input | 1 | Secure window select |
| s_penable_i | input | 1 | Secure window access phase |
| s_pwrite_i | input | 1 | Secure window write |
| s_paddr_i | input | 12 | Secure window byte offset |
| s_psize_i | input | 2 | Secure access size: 0 byte, 1 half, 2 word |
| s_pwdata_i | input | 32 | Secure write data |
| s_prdata_o | output | 32 | Secure read data, valid in access phase |
| ns_psel_i | input | 1 | Non-secure window select |
| ns_penable_i | input | 1 | Non-secure window access phase |
| ns_pwrite_i | input | 1 | Non-secure window write |
| ns_paddr_i | input | 12 | Non-secure window byte offset |
| ns_psize_i | input | 2 | Non-secure access size |
| ns_pwdata_i | input | 32 | Non-secure write data |
| ns_prdata_o | output | 32 | Non-secure read data |
| nonsec_o | output | 320 | Per-port non-secure flags, 32-bit slot per controller |
| ap_o | output | 320 | Per-port access-permission flags, same layout |

## Verification
The hardest case to reach is a single controller whose access-permission bits come from both privilege masks at once. That needs distinct, non-overlapping patterns loaded into the secure-privilege mask from the secure window and into the non-secure-privilege mask from the non-secure window. The non-secure mask is then moved through partial and full patterns. The stimulus does this on expansion AHB controller 2 and predicts `ap_o` bit by bit after each step. It also exercises an internal APB controller whose only secure-privilege bit must be hidden while its port is non-secure, and shown again once the port returns to secure.

// File: rtl/prot_cfg_pkg.sv
package prot_cfg_pkg;
  localparam int REG_W        = 32;
  localparam int NUM_APB_INT  = 2;
  localparam int NUM_APB_EXP  = 4;
  localparam int NUM_AHB_EXP  = 4;
  localparam int APB_INT_BASE = 0;
  localparam int APB_EXP_BASE = APB_INT_BASE + NUM_APB_INT;
  localparam int AHB_EXP_BASE = APB_EXP_BASE + NUM_APB_EXP;
  localparam int NUM_PPC      = AHB_EXP_BASE + NUM_AHB_EXP;
  localparam int IDX_W        = $clog2(NUM_PPC);

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef enum logic [1:0] {SEL_NONE, SEL_NS, SEL_SP, SEL_NSP} mask_sel_e;

  typedef struct packed {
    mask_sel_e        sel;
    logic [IDX_W-1:0] idx;
  } dec_t;

  function automatic logic [REG_W-1:0] low_ones(input int n);
    logic [REG_W-1:0] r;
    for (int i = 0; i < REG_W; i++) r[i] = (i < n);
    return r;
  endfunction

  // group is addr[11:4], controller within group is addr[3:2]
  function automatic dec_t decode_off(input logic secure, input logic [11:0] addr);
    dec_t       d;
    logic [1:0] sub;
    mask_sel_e  priv;
    sub   = addr[3:2];
    priv  = secure ? SEL_SP : SEL_NSP;
    d.sel = SEL_NONE;
    d.idx = '0;
    case (addr[11:4])
      8'h06: if (secure) begin
        d.sel = SEL_NS; d.idx = IDX_W'(AHB_EXP_BASE + int'(sub));
      end
      8'h07: if (secure && sub < 2'd2) begin
        d.sel = SEL_NS; d.idx = IDX_W'(APB_INT_BASE + int'(sub));
      end
      8'h08: if (secure) begin
        d.sel = SEL_NS; d.idx = IDX_W'(APB_EXP_BASE + int'(sub));
      end
      8'h0A: begin
        d.sel = priv; d.idx = IDX_W'(AHB_EXP_BASE + int'(sub));
      end
      8'h0B: if (sub < 2'd2) begin
        d.sel = priv; d.idx = IDX_W'(APB_INT_BASE + int'(sub));
      end
      8'h0C: begin
        d.sel = priv; d.idx = IDX_W'(APB_EXP_BASE + int'(sub));
      end
      default: d.sel = SEL_NONE;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/prot_cfg_ctrl.sv
module prot_cfg_ctrl
  import prot_cfg_pkg::*;
#(
  parameter int PORTS = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_ns_i,
  input  logic             wr_sp_i,
  input  logic             wr_nsp_i,
  input  logic [REG_W-1:0] ns_d_i,
  input  logic [REG_W-1:0] sp_d_i,
  input  logic [REG_W-1:0] nsp_d_i,
  output logic [REG_W-1:0] ns_q_o,
  output logic [REG_W-1:0] sp_q_o,
  output logic [REG_W-1:0] nsp_q_o,
  output logic [REG_W-1:0] ap_o
);
  localparam logic [REG_W-1:0] KEEP = low_ones(PORTS);

  logic [REG_W-1:0] ns_n, sp_n, nsp_n;

  always_comb begin
    ns_n  = wr_ns_i  ? (ns_d_i  & KEEP) : ns_q_o;
    sp_n  = wr_sp_i  ? (sp_d_i  & KEEP) : sp_q_o;
    nsp_n = wr_nsp_i ? (nsp_d_i & KEEP) : nsp_q_o;
  end

  // ap registered from next-state masks so it moves on the same edge as the write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ns_q_o  <= '0;
      sp_q_o  <= '0;
      nsp_q_o <= '0;
      ap_o    <= '0;
    end else begin
      ns_q_o  <= ns_n;
      sp_q_o  <= sp_n;
      nsp_q_o <= nsp_n;
      ap_o    <= (ns_n & nsp_n) | (~ns_n & sp_n);
    end
  end
endmodule

// File: rtl/prot_cfg_win.sv
module prot_cfg_win
  import prot_cfg_pkg::*;
#(
  parameter bit SECURE = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               psel_i,
  input  logic               penable_i,
  input  logic               pwrite_i,
  input  logic [11:0]        paddr_i,
  input  logic [1:0]         psize_i,
  input  logic [REG_W-1:0]   ns_q_i  [NUM_PPC],
  input  logic [REG_W-1:0]   sp_q_i  [NUM_PPC],
  input  logic [REG_W-1:0]   nsp_q_i [NUM_PPC],
  output logic [NUM_PPC-1:0] wr_ns_o,
  output logic [NUM_PPC-1:0] wr_sp_o,
  output logic [NUM_PPC-1:0] wr_nsp_o,
  output logic [REG_W-1:0]   prdata_o
);
  dec_t             dec;
  logic             wr_ok;
  logic [REG_W-1:0] word, shifted, rd_val;

  assign dec   = decode_off(SECURE, paddr_i);
  assign wr_ok = psel_i && penable_i && pwrite_i && (psize_i == SZ_WORD) && (paddr_i[1:0] == 2'b00);

  always_comb begin
    for (int k = 0; k < NUM_PPC; k++) begin
      wr_ns_o[k]  = wr_ok && (dec.sel == SEL_NS)  && (dec.idx == IDX_W'(k));
      wr_sp_o[k]  = wr_ok && (dec.sel == SEL_SP)  && (dec.idx == IDX_W'(k));
      wr_nsp_o[k] = wr_ok && (dec.sel == SEL_NSP) && (dec.idx == IDX_W'(k));
    end
  end

  always_comb begin
    case (dec.sel)
      SEL_NS:  word = ns_q_i[dec.idx];
      SEL_SP:  word = sp_q_i[dec.idx];
      SEL_NSP: word = nsp_q_i[dec.idx];
      default: word = '0;
    endcase
    shifted = word >> {paddr_i[1:0], 3'b000};
    case (psize_i)
      SZ_BYTE: rd_val = REG_W'(shifted[7:0]);
      SZ_HALF: rd_val = REG_W'(shifted[15:0]);
      default: rd_val = word;
    endcase
  end

  // read data captured in setup phase, valid during access phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              prdata_o <= '0;
    else if (psel_i && !penable_i && !pwrite_i) prdata_o <= rd_val;
  end
endmodule

// File: rtl/prot_cfg_top.sv
module prot_cfg_top
  import prot_cfg_pkg::*;
#(
  parameter int APB0_PORTS = 13,
  parameter int APB1_PORTS = 1,
  parameter int EXP_PORTS  = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       s_psel_i,
  input  logic                       s_penable_i,
  input  logic                       s_pwrite_i,
  input  logic [11:0]                s_paddr_i,
  input  logic [1:0]                 s_psize_i,
  input  logic [31:0]                s_pwdata_i,
  output logic [31:0]                s_prdata_o,
  input  logic                       ns_psel_i,
  input  logic                       ns_penable_i,
  input  logic                       ns_pwrite_i,
  input  logic [11:0]                ns_paddr_i,
  input  logic [1:0]                 ns_psize_i,
  input  logic [31:0]                ns_pwdata_i,
  output logic [31:0]                ns_prdata_o,
  output logic [NUM_PPC*REG_W-1:0]   nonsec_o,
  output logic [NUM_PPC*REG_W-1:0]   ap_o
);
  logic [REG_W-1:0]   ns_q [NUM_PPC];
  logic [REG_W-1:0]   sp_q [NUM_PPC];
  logic [REG_W-1:0]   nsp_q [NUM_PPC];
  logic [REG_W-1:0]   ap_q [NUM_PPC];
  logic [NUM_PPC-1:0] s_wr_ns, s_wr_sp, s_wr_nsp;
  logic [NUM_PPC-1:0] n_wr_ns, n_wr_sp, n_wr_nsp;
  logic [NUM_PPC*REG_W-1:0] sp_all, nsp_all;

  prot_cfg_win #(.SECURE(1'b1)) u_win_s (
    .clk_i, .rst_ni,
    .psel_i(s_psel_i), .penable_i(s_penable_i), .pwrite_i(s_pwrite_i),
    .paddr_i(s_paddr_i), .psize_i(s_psize_i),
    .ns_q_i(ns_q), .sp_q_i(sp_q), .nsp_q_i(nsp_q),
    .wr_ns_o(s_wr_ns), .wr_sp_o(s_wr_sp), .wr_nsp_o(s_wr_nsp),
    .prdata_o(s_prdata_o)
  );

  prot_cfg_win #(.SECURE(1'b0)) u_win_ns (
    .clk_i, .rst_ni,
    .psel_i(ns_psel_i), .penable_i(ns_penable_i), .pwrite_i(ns_pwrite_i),
    .paddr_i(ns_paddr_i), .psize_i(ns_psize_i),
    .ns_q_i(ns_q), .sp_q_i(sp_q), .nsp_q_i(nsp_q),
    .wr_ns_o(n_wr_ns), .wr_sp_o(n_wr_sp), .wr_nsp_o(n_wr_nsp),
    .prdata_o(ns_prdata_o)
  );

  for (genvar k = 0; k < NUM_PPC; k++) begin : g_ppc
    localparam int PORTS = (k == APB_INT_BASE)     ? APB0_PORTS :
                           (k == APB_INT_BASE + 1) ? APB1_PORTS : EXP_PORTS;
    prot_cfg_ctrl #(.PORTS(PORTS)) u_ctrl (
      .clk_i, .rst_ni,
      .wr_ns_i (s_wr_ns[k]  | n_wr_ns[k]),
      .wr_sp_i (s_wr_sp[k]  | n_wr_sp[k]),
      .wr_nsp_i(s_wr_nsp[k] | n_wr_nsp[k]),
      .ns_d_i  (s_wr_ns[k]  ? s_pwdata_i : ns_pwdata_i),
      .sp_d_i  (s_wr_sp[k]  ? s_pwdata_i : ns_pwdata_i),
      .nsp_d_i (s_wr_nsp[k] ? s_pwdata_i : ns_pwdata_i),
      .ns_q_o  (ns_q[k]),
      .sp_q_o  (sp_q[k]),
      .nsp_q_o (nsp_q[k]),
      .ap_o    (ap_q[k])
    );
    assign nonsec_o[k*REG_W +: REG_W] = ns_q[k];
    assign ap_o[k*REG_W +: REG_W]     = ap_q[k];
    assign sp_all[k*REG_W +: REG_W]   = sp_q[k];
    assign nsp_all[k*REG_W +: REG_W]  = nsp_q[k];
  end
endmodule

// File: rtl/prot_cfg_chk.sv
module prot_cfg_chk
  import prot_cfg_pkg::*;
#(
  parameter int APB0_PORTS = 13,
  parameter int APB1_PORTS = 1,
  parameter int EXP_PORTS  = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     s_psel_i,
  input logic                     s_penable_i,
  input logic                     s_pwrite_i,
  input logic [11:0]              s_paddr_i,
  input logic [1:0]               s_psize_i,
  input logic                     ns_psel_i,
  input logic                     ns_penable_i,
  input logic                     ns_pwrite_i,
  input logic [NUM_PPC*REG_W-1:0] nonsec_i,
  input logic [NUM_PPC*REG_W-1:0] ap_i,
  input logic [NUM_PPC*REG_W-1:0] sp_all_i,
  input logic [NUM_PPC*REG_W-1:0] nsp_all_i
);
  function automatic logic [NUM_PPC*REG_W-1:0] valid_all();
    logic [NUM_PPC*REG_W-1:0] v;
    for (int k = 0; k < NUM_PPC; k++) begin
      int n;
      n = (k == APB_INT_BASE) ? APB0_PORTS : (k == APB_INT_BASE + 1) ? APB1_PORTS : EXP_PORTS;
      v[k*REG_W +: REG_W] = low_ones(n);
    end
    return v;
  endfunction

  localparam logic [NUM_PPC*REG_W-1:0] VALID = valid_all();

  logic s_wr, ns_wr;
  assign s_wr  = s_psel_i && s_penable_i && s_pwrite_i;
  assign ns_wr = ns_psel_i && ns_penable_i && ns_pwrite_i;

  // R3
  ap_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ap_i == ((nonsec_i & nsp_all_i) | (~nonsec_i & sp_all_i)));

  // R9
  port_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((nonsec_i | ap_i | sp_all_i | nsp_all_i) & ~VALID) == '0);

  // R7
  narrow_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_wr && s_psize_i != SZ_WORD && !ns_wr) |=> ($stable(nonsec_i) && $stable(ap_i)));

  // R5
  ns_view_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ns_wr && !s_wr) |=> $stable(nonsec_i));

  // R6
  hole_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_wr && (s_paddr_i == 12'h050 || s_paddr_i == 12'h090) && !ns_wr)
    |=> ($stable(nonsec_i) && $stable(ap_i)));
endmodule

bind prot_cfg_top prot_cfg_chk #(
  .APB0_PORTS(APB0_PORTS), .APB1_PORTS(APB1_PORTS), .EXP_PORTS(EXP_PORTS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .s_psel_i(s_psel_i), .s_penable_i(s_penable_i), .s_pwrite_i(s_pwrite_i),
  .s_paddr_i(s_paddr_i), .s_psize_i(s_psize_i),
  .ns_psel_i(ns_psel_i), .ns_penable_i(ns_penable_i), .ns_pwrite_i(ns_pwrite_i),
  .nonsec_i(nonsec_o), .ap_i(ap_o), .sp_all_i(sp_all), .nsp_all_i(nsp_all)
);

// File: tb/tb_prot_cfg_top.sv
`timescale 1ns/1ps
module tb_prot_cfg_top;
  import prot_cfg_pkg::*;

  localparam int OW = NUM_PPC * REG_W;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        s_psel = 0, s_penable = 0, s_pwrite = 0;
  logic [11:0] s_paddr = '0;
  logic [1:0]  s_psize = '0;
  logic [31:0] s_pwdata = '0, s_prdata;
  logic        ns_psel = 0, ns_penable = 0, ns_pwrite = 0;
  logic [11:0] ns_paddr = '0;
  logic [1:0]  ns_psize = '0;
  logic [31:0] ns_pwdata = '0, ns_prdata;
  logic [OW-1:0] nonsec, ap;

  always #2 clk = ~clk;

  prot_cfg_top #(.APB0_PORTS(13), .APB1_PORTS(1), .EXP_PORTS(16)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .s_psel_i(s_psel), .s_penable_i(s_penable), .s_pwrite_i(s_pwrite),
    .s_paddr_i(s_paddr), .s_psize_i(s_psize), .s_pwdata_i(s_pwdata), .s_prdata_o(s_prdata),
    .ns_psel_i(ns_psel), .ns_penable_i(ns_penable), .ns_pwrite_i(ns_pwrite),
    .ns_paddr_i(ns_paddr), .ns_psize_i(ns_psize), .ns_pwdata_i(ns_pwdata), .ns_prdata_o(ns_prdata),
    .nonsec_o(nonsec), .ap_o(ap)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(input string req, input string what, input logic [OW-1:0] act, input logic [OW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apb(input bit sec, input bit wr, input logic [1:0] size, input logic [11:0] addr,
                     input logic [31:0] data, output logic [31:0] rd);
    @(negedge clk);
    if (sec) begin
      s_psel = 1; s_penable = 0; s_pwrite = wr; s_paddr = addr; s_psize = size; s_pwdata = data;
    end else begin
      ns_psel = 1; ns_penable = 0; ns_pwrite = wr; ns_paddr = addr; ns_psize = size; ns_pwdata = data;
    end
    @(negedge clk);
    if (sec) s_penable = 1; else ns_penable = 1;
    rd = sec ? s_prdata : ns_prdata;
    @(negedge clk);
    s_psel = 0; s_penable = 0; s_pwrite = 0;
    ns_psel = 0; ns_penable = 0; ns_pwrite = 0;
  endtask

  // {secure, write, size, addr, wdata, expected read, requirement}
  localparam int NV = 39;
  localparam logic [83:0] VEC [NV] = '{
    {1'b1,1'b1,2'd2,12'h070,32'hFFFF_FFFF,32'h0,4'd9},       // R9 apb0 keeps 13 bits
    {1'b1,1'b0,2'd2,12'h070,32'h0,32'h0000_1FFF,4'd9},
    {1'b1,1'b1,2'd2,12'h074,32'hFFFF_FFFF,32'h0,4'd9},
    {1'b1,1'b0,2'd2,12'h074,32'h0,32'h0000_0001,4'd9},
    {1'b1,1'b1,2'd2,12'h084,32'h0000_A5A5,32'h0,4'd4},       // R4 apb exp 1
    {1'b1,1'b0,2'd2,12'h084,32'h0,32'h0000_A5A5,4'd4},
    {1'b1,1'b0,2'd2,12'h080,32'h0,32'h0,4'd4},
    {1'b1,1'b1,2'd2,12'h06C,32'h1234_5678,32'h0,4'd2},       // R2 ahb exp 3
    {1'b1,1'b0,2'd2,12'h06C,32'h0,32'h0000_5678,4'd2},
    {1'b1,1'b1,2'd2,12'h0A8,32'h0000_00FF,32'h0,4'd5},       // R5 secure-priv
    {1'b0,1'b0,2'd2,12'h0A8,32'h0,32'h0,4'd5},
    {1'b0,1'b1,2'd2,12'h0A8,32'h0000_0F0F,32'h0,4'd5},
    {1'b1,1'b0,2'd2,12'h0A8,32'h0,32'h0000_00FF,4'd5},
    {1'b0,1'b0,2'd2,12'h0A8,32'h0,32'h0000_0F0F,4'd5},
    {1'b0,1'b1,2'd2,12'h070,32'h0000_FFFF,32'h0,4'd5},       // R5 ns view cannot reach ns mask
    {1'b1,1'b0,2'd2,12'h070,32'h0,32'h0000_1FFF,4'd5},
    {1'b0,1'b0,2'd2,12'h070,32'h0,32'h0,4'd6},
    {1'b1,1'b1,2'd1,12'h080,32'hFFFF_FFFF,32'h0,4'd7},       // R7 narrow writes
    {1'b1,1'b1,2'd0,12'h080,32'hFFFF_FFFF,32'h0,4'd7},
    {1'b1,1'b1,2'd2,12'h082,32'hFFFF_FFFF,32'h0,4'd7},
    {1'b1,1'b0,2'd2,12'h080,32'h0,32'h0,4'd7},
    {1'b1,1'b1,2'd2,12'h050,32'hFFFF_FFFF,32'h0,4'd6},       // R6 holes
    {1'b1,1'b0,2'd2,12'h050,32'h0,32'h0,4'd6},
    {1'b1,1'b1,2'd2,12'h090,32'hFFFF_FFFF,32'h0,4'd6},
    {1'b1,1'b0,2'd2,12'h090,32'h0,32'h0,4'd6},
    {1'b1,1'b1,2'd2,12'h078,32'h0000_FFFF,32'h0,4'd4},
    {1'b1,1'b0,2'd2,12'h078,32'h0,32'h0,4'd4},
    {1'b1,1'b0,2'd0,12'h06D,32'h0,32'h0000_0056,4'd8},       // R8 lanes
    {1'b1,1'b0,2'd0,12'h06C,32'h0,32'h0000_0078,4'd8},
    {1'b1,1'b0,2'd1,12'h06E,32'h0,32'h0,4'd8},
    {1'b1,1'b0,2'd1,12'h085,32'h0,32'h0000_00A5,4'd8},
    {1'b1,1'b0,2'd2,12'h06E,32'h0,32'h0000_5678,4'd8},
    {1'b0,1'b0,2'd2,12'hFE0,32'h0,32'h0,4'd6},
    {1'b1,1'b1,2'd2,12'h0B4,32'hFFFF_FFFF,32'h0,4'd9},
    {1'b1,1'b0,2'd2,12'h0B4,32'h0,32'h0000_0001,4'd9},
    {1'b0,1'b1,2'd2,12'h0C0,32'h0000_3C3C,32'h0,4'd5},
    {1'b0,1'b0,2'd2,12'h0C0,32'h0,32'h0000_3C3C,4'd5},
    {1'b1,1'b0,2'd2,12'h0C0,32'h0,32'h0,4'd5},
    {1'b1,1'b0,2'd2,12'h0A0,32'h0,32'h0,4'd4}
  };

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0]   rd;
    logic [OW-1:0] e_ns, e_ap;
    repeat (3) @(negedge clk);
    check("R1", "nonsec in reset", nonsec, '0);
    check("R1", "ap in reset", ap, '0);
    rst_ni = 1'b1;
    apb(1, 0, SZ_WORD, 12'h070, 0, rd);
    check("R1", "apb0 ns after reset", OW'(rd), '0);
    apb(0, 0, SZ_WORD, 12'h0A0, 0, rd);
    check("R1", "nsp after reset", OW'(rd), '0);

    for (int i = 0; i < NV; i++) begin
      apb(VEC[i][83], VEC[i][82], VEC[i][81:80], VEC[i][79:68], VEC[i][67:36], rd);
      if (!VEC[i][82])
        check($sformatf("R%0d", VEC[i][3:0]), $sformatf("vec %0d", i), OW'(rd), OW'(VEC[i][35:4]));
    end

    // R2 slot layout of nonsec after table
    e_ns = '0;
    e_ns[0*32 +: 32] = 32'h0000_1FFF;
    e_ns[1*32 +: 32] = 32'h0000_0001;
    e_ns[3*32 +: 32] = 32'h0000_A5A5;
    e_ns[9*32 +: 32] = 32'h0000_5678;
    check("R2", "nonsec slots", nonsec, e_ns);
    // R3 slot1 secure-priv hidden (port non-secure), slot8 secure ports take sp
    e_ap = '0;
    e_ap[8*32 +: 32] = 32'h0000_00FF;
    check("R3", "ap after table", ap, e_ap);

    apb(1, 1, SZ_WORD, 12'h068, 32'h0000_00F0, rd);
    e_ns[8*32 +: 32] = 32'h0000_00F0;
    e_ap[8*32 +: 32] = 32'h0000_000F;
    check("R2", "nonsec ahb2 partial", nonsec, e_ns);
    check("R3", "ap mixed select", ap, e_ap);

    apb(1, 1, SZ_WORD, 12'h068, 32'h0000_FFFF, rd);
    e_ns[8*32 +: 32] = 32'h0000_FFFF;
    e_ap[8*32 +: 32] = 32'h0000_0F0F;
    check("R3", "ap all non-secure", ap, e_ap);

    apb(1, 1, SZ_WORD, 12'h074, 32'h0, rd);
    e_ns[1*32 +: 32] = 32'h0;
    e_ap[1*32 +: 32] = 32'h0000_0001;
    check("R3", "apb1 back to secure", ap, e_ap);
    check("R2", "apb1 ns cleared", nonsec, e_ns);

    apb(1, 1, SZ_HALF, 12'h068, 32'h0, rd);
    check("R7", "half write keeps ns", nonsec, e_ns);
    apb(0, 1, SZ_WORD, 12'h068, 32'h0, rd);
    check("R5", "ns view write to ns offset", nonsec, e_ns);
    apb(1, 1, SZ_WORD, 12'h090, 32'hFFFF_FFFF, rd);
    check("R6", "hole write keeps ap", ap, e_ap);

    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    check("R1", "nonsec mid-run reset", nonsec, '0);
    check("R1", "ap mid-run reset", ap, '0);
    rst_ni = 1'b1;
    apb(1, 0, SZ_WORD, 12'h06C, 0, rd);
    check("R1", "ahb3 ns after reset", OW'(rd), '0);
    apb(1, 0, SZ_WORD, 12'h0A8, 0, rd);
    check("R1", "sp after reset", OW'(rd), '0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule